// File: doc/BRIEF.md
# Cache Event Monitor Counter

This block is a run-time selectable performance counter placed next to a cache controller. Each cycle it sees three event inputs from the cache: a clock-enable tick, an instruction-hit pulse and a data-hit pulse. A two-bit selector picks which one of these the counter follows. Counting happens only while the monitor is enabled. A separate write-only strobe clears the count without touching the enable or the selector.

Software reaches the block through a simple register-write port and a combinational register-read port, each with a two-bit address. The word address map is: 0 is the selector, 1 is the enable, 2 is the clear strobe and 3 is the count. The enable is held by a two-state machine. `MON_OFF` is the reset state. The transition `T_START` goes from `MON_OFF` to `MON_RUN` when bit 0 of a write to address 1 is 1. The transition `T_STOP` goes from `MON_RUN` back to `MON_OFF` when bit 0 of a write to address 1 is 0. Every other cycle keeps the current state.

Top module: `cache_evt_monitor`

## Requirements
- R1: After reset, reads of the selector (address 0), the enable (address 1) and the count (address 3) all return 0.
- R2: With selector value 0 and the monitor enabled, the count goes up by one for each cycle in which the tick input is high, and the hit inputs have no effect.
- R3: With selector value 1 and the monitor enabled, the count goes up by one for each cycle in which the instruction-hit input is high, and the other two inputs have no effect.
- R4: With selector value 2 and the monitor enabled, the count goes up by one for each cycle in which the data-hit input is high, and the other two inputs have no effect.
- R5: Selector value 3 counts nothing, whatever the event inputs do.
- R6: While the enable is 0, the count holds its value under any event pattern.
- R7: A write to address 2 with bit 0 set clears the count at that clock edge. A write to address 2 with bit 0 clear has no effect, and reads of address 2 return 0.
- R8: When a clear write and a counted event fall in the same cycle, the count reads 0 afterwards.
- R9: A new selector value applies to events from the cycle after its write. Events in the write cycle are judged by the old value, and the count built up so far is kept.
- R10: When the count is all ones and one more event is counted, it wraps to 0 and then keeps counting from there.
- R11: Only bits 1:0 of the selector and bit 0 of the enable can be written, and the other bits read as 0. Writes to address 3 leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | Per-cycle clock-enable tick from the cache |
| ihit | input | 1 | Instruction-hit pulse |
| dhit | input | 1 | Data-hit pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write word address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read word address |
| rd_data | output | DATA_W | Register read data (combinational) |

## Verification
On every cycle, the assertions check the counter's step rules: a clear leaves the count at zero, a counted event adds exactly one with wrap, and the count holds when there is no event. They also check that selector value 3 and a disabled monitor never produce a count pulse, and that the selector changes only on its own write. The directed scenarios show the behaviour seen at the register ports. This covers which source each selector value follows, the one-cycle delay before a new selector value applies, the effect of a clear that lands on an event, the write masks, and the wrap. The wrap is shown on a second instance with an 8-bit counter.

// File: rtl/cevm_pkg.sv
package cevm_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        EV_CYCLE = 2'd0,
        EV_IHIT  = 2'd1,
        EV_DHIT  = 2'd2,
        EV_NONE  = 2'd3
    } ev_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE = 2'd0,
        REG_EN   = 2'd1,
        REG_CLR  = 2'd2,
        REG_CNT  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        MON_OFF = 1'b0,
        MON_RUN = 1'b1
    } mon_state_e;

endpackage

// File: rtl/cevm_regs.sv
module cevm_regs
    import cevm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ev_mode_e          mode,
    output logic              en,
    output logic              clr
);

    logic       wr_mode, wr_en_reg, wr_clr;
    mon_state_e state_q, state_d;
    logic       unused_wr_hi;

    assign unused_wr_hi = ^wr_data[DATA_W-1:2];

    assign wr_mode   = wr_en && (wr_addr == REG_MODE);
    assign wr_en_reg = wr_en && (wr_addr == REG_EN);
    assign wr_clr    = wr_en && (wr_addr == REG_CLR);

    // selector register, only bits 1:0 are kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode <= EV_CYCLE;
        else if (wr_mode)
            mode <= ev_mode_e'(wr_data[1:0]);
    end

    // enable state machine: next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_OFF: if (wr_en_reg && wr_data[0])  state_d = MON_RUN; // T_START
            MON_RUN: if (wr_en_reg && !wr_data[0]) state_d = MON_OFF; // T_STOP
            default: state_d = MON_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= MON_OFF;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        en  = 1'b0;
        clr = wr_clr && wr_data[0];
        unique case (state_q)
            MON_OFF: en = 1'b0;
            MON_RUN: en = 1'b1;
            default: en = 1'b0;
        endcase
    end

    // R11: the selector changes only on its own write
    a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> $stable(mode));

    // R6: the enable changes only on its own write
    a_r6_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_reg |=> $stable(en));

endmodule

// File: rtl/cevm_event_sel.sv
module cevm_event_sel
    import cevm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ev_mode_e mode,
    input  logic     en,
    input  logic     cyc_tick,
    input  logic     ihit,
    input  logic     dhit,
    output logic     inc
);

    logic picked;

    always_comb begin
        picked = 1'b0;
        unique case (mode)
            EV_CYCLE: picked = cyc_tick;
            EV_IHIT:  picked = ihit;
            EV_DHIT:  picked = dhit;
            EV_NONE:  picked = 1'b0;
            default:  picked = 1'b0;
        endcase
    end

    assign inc = en && picked;

    // R5: reserved selector never counts
    a_r5_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EV_NONE) |-> !inc);

    // R6: disabled monitor never counts
    a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !inc);

endmodule

// File: rtl/cevm_counter.sv
module cevm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    // R8: clear beats any event in the same cycle
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R10: a counted event adds exactly one, wrapping at all ones
    a_r10_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R6: without event or clear the count holds
    a_r6_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/cache_evt_monitor.sv
module cache_evt_monitor
    import cevm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_tick,
    input  logic              ihit,
    input  logic              dhit,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    ev_mode_e         mode;
    logic             en, clr, inc;
    logic [CNT_W-1:0] cnt;

    cevm_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode    (mode),
        .en      (en),
        .clr     (clr)
    );

    cevm_event_sel u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .en       (en),
        .cyc_tick (cyc_tick),
        .ihit     (ihit),
        .dhit     (dhit),
        .inc      (inc)
    );

    cevm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (inc),
        .cnt   (cnt)
    );

    // read mux: the clear strobe and unused bits read as zero
    always_comb begin
        rd_data = '0;
        unique case (reg_addr_e'(rd_addr))
            REG_MODE: rd_data = DATA_W'(mode);
            REG_EN:   rd_data = DATA_W'(en);
            REG_CLR:  rd_data = '0;
            REG_CNT:  rd_data = DATA_W'(cnt);
            default:  rd_data = '0;
        endcase
    end

    // R7: the clear strobe always reads back as zero
    a_r7_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == REG_CLR) |-> (rd_data == '0));

endmodule

// File: tb/cache_evt_monitor_tb.sv
module cache_evt_monitor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_tick = 1'b0, ihit = 1'b0, dhit = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data, rd_data_n;
    int          n_vec = 0, n_bad = 0;

    always #10 clk = ~clk;

    cache_evt_monitor #(.DATA_W(32), .CNT_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ihit(ihit), .dhit(dhit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    cache_evt_monitor #(.DATA_W(32), .CNT_W(8)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ihit(ihit), .dhit(dhit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data_n)
    );

    // one clock: inputs set after a falling edge, result visible at the next one
    task automatic drive(input logic we, input logic [1:0] a, input logic [31:0] d,
                         input logic t, input logic i, input logic h);
        wr_en = we; wr_addr = a; wr_data = d;
        cyc_tick = t; ihit = i; dhit = h;
        @(negedge clk);
        wr_en = 1'b0; cyc_tick = 1'b0; ihit = 1'b0; dhit = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        drive(1'b1, a, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic check(input string req, input logic [1:0] a,
                         input logic [31:0] exp, input logic narrow);
        logic [31:0] got;
        rd_addr = a;
        #1;
        got = narrow ? rd_data_n : rd_data;
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, got, exp);
        end
    endtask

    task automatic t_reset;
        check("R1", 2'd0, 32'd0, 1'b0);
        check("R1", 2'd1, 32'd0, 1'b0);
        check("R1", 2'd3, 32'd0, 1'b0);
    endtask

    task automatic t_cycle;
        wreg(2'd0, 32'd0); wreg(2'd1, 32'd1); wreg(2'd2, 32'd1);
        for (int k = 0; k < 10; k++)
            drive(1'b0, 2'd0, 32'd0, (k % 3) != 0, 1'b1, k[0]);
        check("R2", 2'd3, 32'd6, 1'b0);
    endtask

    task automatic t_ihit;
        wreg(2'd0, 32'd1); wreg(2'd2, 32'd1);
        for (int k = 0; k < 8; k++)
            drive(1'b0, 2'd0, 32'd0, 1'b1, k < 5, k != 3);
        check("R3", 2'd3, 32'd5, 1'b0);
    endtask

    task automatic t_dhit;
        wreg(2'd0, 32'd2); wreg(2'd2, 32'd1);
        for (int k = 0; k < 9; k++)
            drive(1'b0, 2'd0, 32'd0, 1'b1, 1'b1, k[0]);
        check("R4", 2'd3, 32'd4, 1'b0);
    endtask

    task automatic t_reserved;
        wreg(2'd0, 32'd3); wreg(2'd2, 32'd1);
        for (int k = 0; k < 6; k++)
            drive(1'b0, 2'd0, 32'd0, 1'b1, 1'b1, 1'b1);
        check("R5", 2'd0, 32'd3, 1'b0);
        check("R5", 2'd3, 32'd0, 1'b0);
    endtask

    task automatic t_disable;
        wreg(2'd0, 32'd0); wreg(2'd2, 32'd1);
        for (int k = 0; k < 4; k++) drive(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        wreg(2'd1, 32'd0);
        for (int k = 0; k < 5; k++) drive(1'b0, 2'd0, 32'd0, 1'b1, 1'b1, 1'b1);
        check("R6", 2'd1, 32'd0, 1'b0);
        check("R6", 2'd3, 32'd4, 1'b0);
        wreg(2'd1, 32'd1);
        drive(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        check("R6", 2'd3, 32'd5, 1'b0);
    endtask

    task automatic t_swrst;
        check("R7", 2'd2, 32'd0, 1'b0);
        wreg(2'd2, 32'hFFFF_FFFE);
        check("R7", 2'd3, 32'd5, 1'b0);
        wreg(2'd2, 32'd1);
        check("R7", 2'd3, 32'd0, 1'b0);
        check("R7", 2'd1, 32'd1, 1'b0);
    endtask

    task automatic t_clear_wins;
        drive(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 2'd2, 32'd1, 1'b1, 1'b0, 1'b0);
        check("R8", 2'd3, 32'd0, 1'b0);
        drive(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        check("R8", 2'd3, 32'd1, 1'b0);
    endtask

    task automatic t_mode_switch;
        wreg(2'd0, 32'd1); wreg(2'd2, 32'd1);
        for (int k = 0; k < 3; k++) drive(1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0);
        check("R9", 2'd3, 32'd3, 1'b0);
        drive(1'b1, 2'd0, 32'd2, 1'b0, 1'b1, 1'b1);
        check("R9", 2'd3, 32'd4, 1'b0);
        drive(1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0);
        check("R9", 2'd3, 32'd4, 1'b0);
        drive(1'b0, 2'd0, 32'd0, 1'b0, 1'b0, 1'b1);
        check("R9", 2'd3, 32'd5, 1'b0);
    endtask

    task automatic t_masks;
        wreg(2'd0, 32'hFFFF_FFFE);
        check("R11", 2'd0, 32'd2, 1'b0);
        wreg(2'd1, 32'hFFFF_FFFE);
        check("R11", 2'd1, 32'd0, 1'b0);
        wreg(2'd1, 32'hFFFF_FFFF);
        check("R11", 2'd1, 32'd1, 1'b0);
        wreg(2'd3, 32'h0000_0077);
        check("R11", 2'd3, 32'd5, 1'b0);
    endtask

    task automatic t_wrap;
        wreg(2'd0, 32'd0); wreg(2'd2, 32'd1);
        for (int k = 0; k < 255; k++) drive(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        check("R10", 2'd3, 32'd255, 1'b1);
        drive(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        check("R10", 2'd3, 32'd0, 1'b1);
        drive(1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 1'b0);
        check("R10", 2'd3, 32'd1, 1'b1);
        check("R10", 2'd3, 32'd257, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cycle();
        t_ihit();
        t_dhit();
        t_reserved();
        t_disable();
        t_swrst();
        t_clear_wins();
        t_mode_switch();
        t_masks();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule